// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps each virtual address issued by a processor onto physical memory through a small table of segments belonging to the running process. The top bits of the virtual address pick one table entry. The remaining bits are an offset. The offset is checked against the entry's limit and added to the entry's physical base. An entry can be marked read-only. A store to such an entry is refused with its own fault code, which differs from the code for an out-of-limit access.

Only kernel-mode software may change the table or the translation-enable switch. While translation is off, addresses pass straight through, which lets the kernel reach all of memory. An attempt to change either one from user mode has no effect and raises a one-cycle privilege flag. Every request is answered one clock later with either a physical address or a fault code.

Top module: `seg_xlate`

## Requirements
- R1: The top `SEG_BITS` bits of `req_vaddr` select the segment entry, and the low `VA_W-SEG_BITS` bits form the offset.
- R2: With translation enabled, an offset greater than or equal to the entry's limit gives `rsp_fault` = 2'b01 (limit fault) and `rsp_paddr` = 0.
- R3: With translation enabled, a store (`req_write`=1) within the limit of an entry whose read-only flag is set gives `rsp_fault` = 2'b10 (protection fault) and `rsp_paddr` = 0. A load from that entry succeeds. When both conditions hold, the limit fault wins.
- R4: A translated access without a fault gives `rsp_fault` = 2'b00 and `rsp_paddr` = (base + offset) modulo 2^`PA_W`. The sum and the limit compare are computed side by side.
- R5: With translation disabled, `rsp_paddr` equals `req_vaddr` zero-extended and `rsp_fault` = 2'b00, whatever the table holds.
- R6: `cfg_map_we` and `cfg_reloc_we` change the table or the enable switch only when `kernel_mode` is 1. In user mode they leave both unchanged.
- R7: A `cfg_map_we` or `cfg_reloc_we` pulse while `kernel_mode` is 0 drives `priv_fault` high for exactly the following cycle. Otherwise `priv_fault` stays low.
- R8: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and its result belongs to that request.
- R9: After reset, translation is disabled, every entry has base 0, limit 0 and read-write, and `rsp_valid` and `priv_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| kernel_mode | input | 1 | 1 = privileged software is running |
| cfg_map_we | input | 1 | Table entry write strobe |
| cfg_map_idx | input | SEG_BITS | Entry to write |
| cfg_map_base | input | PA_W | New physical base |
| cfg_map_limit | input | VA_W-SEG_BITS+1 | New limit (number of valid offsets) |
| cfg_map_ro | input | 1 | New read-only flag |
| cfg_reloc_we | input | 1 | Translation-enable write strobe |
| cfg_reloc_en | input | 1 | New translation-enable value |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | PA_W | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 00 none, 01 limit, 10 protection |
| priv_fault | output | 1 | User-mode configuration attempt seen last cycle |

## Verification
The hardest condition to reach is an exact limit edge on a store to a read-only entry. There, the limit fault has to take priority over the protection fault, and the access one offset lower has to turn into a protection fault. Random addresses almost never land there. So the bench sets the limits itself and aims directed stores and loads at limit-1, at the limit, and at the full-size limit. It also places a base near the top of physical memory to force the sum to wrap. Random table rewrites, some of them from user mode, run alongside random requests, so that refused writes are shown to have changed nothing.

// File: rtl/seg_xlate_pkg.sv
// Package: types shared by the segmented translation unit.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_LIMIT = 2'b01,
        FLT_PROT  = 2'b10
    } fault_e;
endpackage

// File: rtl/seg_map_regs.sv
// Module: seg_map_regs
// Holds the segment table: base, limit and read-only flag for each entry.
// Assumes writes are already qualified by privilege. The read port is
// combinational, so a read in the cycle of a write sees the old entry.
module seg_map_regs #(
    parameter int SEG_BITS = 2,
    parameter int PA_W     = 20,
    parameter int LIM_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [LIM_W-1:0]    wr_limit,
    input  logic                wr_ro,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic [PA_W-1:0]     rd_base,
    output logic [LIM_W-1:0]    rd_limit,
    output logic                rd_ro
);
    localparam int SEGS = 1 << SEG_BITS;

    logic [PA_W-1:0]  base_q  [SEGS];
    logic [LIM_W-1:0] limit_q [SEGS];
    logic [SEGS-1:0]  ro_q;
    logic [SEGS-1:0]  hit;

    // Per-entry write decode.
    for (genvar g = 0; g < SEGS; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_idx == SEG_BITS'(g));
    end

    // Table storage: cleared on reset, loaded on a decoded hit.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SEGS; i++) begin
            if (!rst_n) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
                ro_q[i]    <= 1'b0;
            end else if (hit[i]) begin
                base_q[i]  <= wr_base;
                limit_q[i] <= wr_limit;
                ro_q[i]    <= wr_ro;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = limit_q[rd_idx];
        rd_ro    = ro_q[rd_idx];
    end
endmodule

// File: rtl/seg_check_add.sv
// Module: seg_check_add
// Computes base+offset and the limit / protection check side by side.
// Purely combinational. Assumes PA_W >= OFF_W and LIM_W = OFF_W+1.
module seg_check_add
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 14,
    parameter int PA_W  = 20,
    parameter int LIM_W = 15
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [LIM_W-1:0] limit,
    input  logic             ro,
    input  logic             is_write,
    output logic [PA_W-1:0]  sum,
    output fault_e           fault
);
    logic over;

    // Adder and comparator are independent paths.
    always_comb begin
        sum  = base + PA_W'(offset);
        over = LIM_W'(offset) >= limit;
        if (over)                fault = FLT_LIMIT;
        else if (ro && is_write) fault = FLT_PROT;
        else                     fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Segmented virtual-to-physical translation with privilege-gated setup.
// Assumes PA_W >= VA_W. The result is registered: one cycle of latency.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W     = 16,
    parameter int PA_W     = 20,
    parameter int SEG_BITS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic                         req_write,
    input  logic                         kernel_mode,
    input  logic                         cfg_map_we,
    input  logic [SEG_BITS-1:0]          cfg_map_idx,
    input  logic [PA_W-1:0]              cfg_map_base,
    input  logic [VA_W-SEG_BITS:0]       cfg_map_limit,
    input  logic                         cfg_map_ro,
    input  logic                         cfg_reloc_we,
    input  logic                         cfg_reloc_en,
    output logic                         rsp_valid,
    output logic [PA_W-1:0]              rsp_paddr,
    output logic [1:0]                   rsp_fault,
    output logic                         priv_fault
);
    localparam int OFF_W = VA_W - SEG_BITS;
    localparam int LIM_W = OFF_W + 1;

    logic                map_we_ok;
    logic                reloc_we_ok;
    logic                reloc_en_q;
    logic [SEG_BITS-1:0] seg_idx;
    logic [OFF_W-1:0]    offset;
    logic [PA_W-1:0]     ent_base;
    logic [LIM_W-1:0]    ent_limit;
    logic                ent_ro;
    logic [PA_W-1:0]     sum;
    fault_e              chk_fault;
    logic [PA_W-1:0]     nxt_paddr;
    fault_e              nxt_fault;

    // Privilege gate on configuration writes.
    always_comb begin
        map_we_ok   = cfg_map_we   && kernel_mode;
        reloc_we_ok = cfg_reloc_we && kernel_mode;
        seg_idx     = req_vaddr[VA_W-1 -: SEG_BITS];
        offset      = req_vaddr[OFF_W-1:0];
    end

    seg_map_regs #(.SEG_BITS(SEG_BITS), .PA_W(PA_W), .LIM_W(LIM_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_we_ok),
        .wr_idx   (cfg_map_idx),
        .wr_base  (cfg_map_base),
        .wr_limit (cfg_map_limit),
        .wr_ro    (cfg_map_ro),
        .rd_idx   (seg_idx),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_ro    (ent_ro)
    );

    seg_check_add #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_chk_add (
        .offset   (offset),
        .base     (ent_base),
        .limit    (ent_limit),
        .ro       (ent_ro),
        .is_write (req_write),
        .sum      (sum),
        .fault    (chk_fault)
    );

    // Translation-enable switch, kernel-writable only.
    always_ff @(posedge clk) begin
        if (!rst_n)           reloc_en_q <= 1'b0;
        else if (reloc_we_ok) reloc_en_q <= cfg_reloc_en;
    end

    // Pick pass-through or translated result; a fault forces address 0.
    always_comb begin
        if (!reloc_en_q) begin
            nxt_paddr = PA_W'(req_vaddr);
            nxt_fault = FLT_NONE;
        end else begin
            nxt_fault = chk_fault;
            nxt_paddr = (chk_fault == FLT_NONE) ? sum : '0;
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_fault  <= FLT_NONE;
            priv_fault <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_paddr  <= req_valid ? nxt_paddr : '0;
            rsp_fault  <= req_valid ? nxt_fault : FLT_NONE;
            priv_fault <= !kernel_mode && (cfg_map_we || cfg_reloc_we);
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Module: seg_xlate_chk
// Property checker bound to seg_xlate. Observes ports and the enable state.
module seg_xlate_chk #(
    parameter int VA_W     = 16,
    parameter int PA_W     = 20,
    parameter int SEG_BITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [VA_W-1:0]     req_vaddr,
    input logic                kernel_mode,
    input logic                cfg_map_we,
    input logic                cfg_reloc_we,
    input logic                reloc_en,
    input logic                rsp_valid,
    input logic [PA_W-1:0]     rsp_paddr,
    input logic [1:0]          rsp_fault,
    input logic                priv_fault
);
    // R2 R3: a faulting response carries no address.
    a_r2_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

    // R3: fault code 2'b11 is never produced.
    a_r3_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b11);

    // R5: pass-through when translation is off.
    a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reloc_en) |=>
            (rsp_fault == 2'b00 && rsp_paddr == PA_W'($past(req_vaddr))));

    // R7: user-mode configuration attempt flags privilege fault next cycle.
    a_r7_priv_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_mode && (cfg_map_we || cfg_reloc_we)) |=> priv_fault);

    // R7: no flag without a user-mode attempt.
    a_r7_priv_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(!kernel_mode && (cfg_map_we || cfg_reloc_we)) |=> !priv_fault);

    // R6: the enable switch never changes after a cycle without a kernel write.
    a_r6_reloc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(kernel_mode && cfg_reloc_we) |=> $stable(reloc_en));

    // R8: response one cycle after each request, and only then.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .SEG_BITS(SEG_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .kernel_mode  (kernel_mode),
    .cfg_map_we   (cfg_map_we),
    .cfg_reloc_we (cfg_reloc_we),
    .reloc_en     (reloc_en_q),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .priv_fault   (priv_fault)
);

// File: tb/seg_xlate_bench.sv
// Bench for seg_xlate: directed corner cases plus seeded random traffic,
// compared against a reference model held in bench variables.
module seg_xlate_bench;
    localparam int VA_W = 16;
    localparam int PA_W = 20;
    localparam int SB   = 2;
    localparam int OFF_W = VA_W - SB;
    localparam int LIM_W = OFF_W + 1;
    localparam int SEGS = 1 << SB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              req_write = 1'b0;
    logic              kernel_mode = 1'b1;
    logic              cfg_map_we = 1'b0;
    logic [SB-1:0]     cfg_map_idx = '0;
    logic [PA_W-1:0]   cfg_map_base = '0;
    logic [LIM_W-1:0]  cfg_map_limit = '0;
    logic              cfg_map_ro = 1'b0;
    logic              cfg_reloc_we = 1'b0;
    logic              cfg_reloc_en = 1'b0;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic [1:0]        rsp_fault;
    logic              priv_fault;

    int checks = 0;
    int errors = 0;

    logic [PA_W-1:0]  m_base  [SEGS];
    logic [LIM_W-1:0] m_limit [SEGS];
    logic             m_ro    [SEGS];
    logic             m_reloc;

    always #5 clk = ~clk;

    seg_xlate #(.VA_W(VA_W), .PA_W(PA_W), .SEG_BITS(SB)) u_seg_xlate (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference result: {fault, paddr}.
    function automatic logic [PA_W+1:0] model(input logic [VA_W-1:0] va, input logic wr);
        logic [SB-1:0]    s;
        logic [OFF_W-1:0] o;
        s = va[VA_W-1 -: SB];
        o = va[OFF_W-1:0];
        if (!m_reloc)                   return {2'b00, PA_W'(va)};
        if (LIM_W'(o) >= m_limit[s])    return {2'b01, PA_W'(0)};
        if (wr && m_ro[s])              return {2'b10, PA_W'(0)};
        return {2'b00, PA_W'(m_base[s] + PA_W'(o))};
    endfunction

    // One request, checked one cycle later.
    task automatic do_req(input logic [VA_W-1:0] va, input logic wr, input string req);
        logic [PA_W+1:0] e;
        e = model(va, wr);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {req, " R8 valid"}, rsp_valid, 1);
        check({rsp_fault, rsp_paddr} == e, req, {rsp_fault, rsp_paddr}, e);
    endtask

    task automatic map_wr(input logic k, input int idx, input logic [PA_W-1:0] b,
                          input logic [LIM_W-1:0] l, input logic ro);
        @(negedge clk);
        kernel_mode = k; cfg_map_we = 1'b1; cfg_map_idx = SB'(idx);
        cfg_map_base = b; cfg_map_limit = l; cfg_map_ro = ro;
        @(negedge clk);
        cfg_map_we = 1'b0; kernel_mode = 1'b1;
        check(priv_fault == !k, "R7 map write flag", priv_fault, !k);
        if (k) begin m_base[idx] = b; m_limit[idx] = l; m_ro[idx] = ro; end
    endtask

    task automatic reloc_wr(input logic k, input logic en);
        @(negedge clk);
        kernel_mode = k; cfg_reloc_we = 1'b1; cfg_reloc_en = en;
        @(negedge clk);
        cfg_reloc_we = 1'b0; kernel_mode = 1'b1;
        check(priv_fault == !k, "R7 reloc write flag", priv_fault, !k);
        if (k) m_reloc = en;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < SEGS; i++) begin m_base[i] = '0; m_limit[i] = '0; m_ro[i] = 1'b0; end
        m_reloc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        check(rsp_valid == 1'b0, "R9 rsp_valid", rsp_valid, 0);
        check(priv_fault == 1'b0, "R9 priv_fault", priv_fault, 0);
        // R5 R9: translation disabled after reset.
        do_req(16'hC123, 1'b1, "R5 passthru after reset");
        // R8: idle cycle gives no response.
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 idle", rsp_valid, 0);
        reloc_wr(1'b1, 1'b1);
        // R9: zero limits make every translated access fault.
        do_req(16'h0000, 1'b0, "R9 R2 zero limit");
        // Program entries: seg0 rw, seg1 ro, seg2 full size, seg3 near top.
        map_wr(1'b1, 0, 20'h10000, 15'd100, 1'b0);
        map_wr(1'b1, 1, 20'h20000, 15'd50,  1'b1);
        map_wr(1'b1, 2, 20'h40000, 15'd16384, 1'b0);
        map_wr(1'b1, 3, 20'hFFFF0, 15'd1000, 1'b0);
        do_req({2'd0, 14'd99},  1'b1, "R4 R1 seg0 last offset");
        do_req({2'd0, 14'd100}, 1'b0, "R2 seg0 at limit");
        do_req({2'd1, 14'd10},  1'b1, "R3 ro store");
        do_req({2'd1, 14'd10},  1'b0, "R3 ro load ok");
        do_req({2'd1, 14'd49},  1'b1, "R3 ro store limit-1");
        do_req({2'd1, 14'd50},  1'b1, "R3 R2 limit beats protection");
        do_req({2'd2, 14'h3FFF}, 1'b1, "R4 full size limit");
        do_req({2'd3, 14'd32},  1'b0, "R4 wrap modulo");
        // R6: user-mode map write ignored, entry observable unchanged.
        map_wr(1'b0, 0, 20'h55555, 15'd5, 1'b1);
        do_req({2'd0, 14'd50},  1'b1, "R6 user map write ignored");
        // R6: user-mode disable ignored.
        reloc_wr(1'b0, 1'b0);
        do_req({2'd0, 14'd7},   1'b0, "R6 user reloc write ignored");
        // Random traffic with occasional reconfiguration.
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r == 0)
                map_wr(($urandom_range(0, 3) != 0), $urandom_range(0, SEGS-1),
                       PA_W'($urandom), LIM_W'($urandom_range(0, 16384)), 1'($urandom));
            else if (r == 1)
                reloc_wr(($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0));
            else
                do_req(VA_W'($urandom), 1'($urandom), "R1 R2 R3 R4 R5 random");
        end
        // R5: disabled again, table ignored.
        reloc_wr(1'b1, 1'b0);
        do_req({2'd1, 14'd60}, 1'b1, "R5 passthru after disable");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule